// File: doc/BRIEF.md
# Grouped Pin Change Interrupt Unit

This unit watches eleven input pins and raises a single interrupt request whenever any of them changes level. Eight of the pins belong to one 8-bit port and three to a second port. The pins fall into two groups, and each group has its own enable bit. A group whose enable is clear cannot set the shared flag at all. Its changes are dropped before the flag, so a disabled group never leaves a pending flag behind.

Any pin that has been handed to an alternate function is kept out of change detection. The caller supplies one suppress bit per pin. Each suppress bit is the OR of whatever conditions assign that pin to another peripheral, and that decoding is done outside this unit. The unit samples the pin level without regard to pin direction. A pin driven as an output can therefore trigger a software interrupt. A pin whose activity also raises some other interrupt still produces a change request here.

The flag stays set until the interrupt controller acknowledges it. The request output follows the flag only while at least one group is enabled.

Top module: `pin_change_irq`

## Requirements
- R1: During and right after reset, `chg_flag` and `irq_req` are 0 and both group enables are treated as cleared.
- R2: A rising or a falling level change on a group-0 pin (`pin_in[3:0]`, the lower four pins of the 8-bit port) with `grp_en[0]`=1 sets `chg_flag` and `irq_req`. They first read 1 after the third rising clock edge following the change: two synchroniser stages and one flag register.
- R3: A level change on a group-1 pin (`pin_in[7:4]`, the upper four pins of the 8-bit port, and `pin_in[10:8]`, which carry pins 3, 6 and 7 of the second port) with `grp_en[1]`=1 sets the flag with the same latency as R2.
- R4: A change on a pin whose group enable is 0 never sets `chg_flag`. Enabling that group afterwards does not set it either.
- R5: While `alt_active[i]`=1, level changes on `pin_in[i]` do not set the flag.
- R6: Clearing `alt_active[i]` after `pin_in[i]` has changed under the mask does not set the flag.
- R7: `ack`=1 clears `chg_flag` at the next rising edge when no enabled, unmasked change is being detected in that cycle.
- R8: When a detected change and `ack` occur in the same cycle, the flag stays set.
- R9: `irq_req` is the flag gated by "any group enabled", registered alongside it. With both enables cleared, `irq_req` drops one edge later while `chg_flag` holds.
- R10: Once set, `chg_flag` holds until acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 11 | Monitored pin levels, asynchronous |
| grp_en | input | 2 | Group enables: bit 0 = group 0, bit 1 = group 1 |
| alt_active | input | 11 | Per-pin alternate-function suppress |
| ack | input | 1 | Clears the flag |
| chg_flag | output | 1 | Shared pin-change flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions assume that `grp_en`, `alt_active` and `ack` are synchronous to `clk` and change only between edges. They also assume that `pin_in` may be asynchronous, because it is synchronised before any property looks at its effect. The bench drives every input at the falling edge. It changes a pin only while the enables and masks under test are already stable. It leaves at least three idle cycles after each pin change, so each expected flag value maps to a single edge.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;
  localparam int PCI_PINS   = 11;
  localparam int PCI_GROUPS = 2;
  localparam int PCI_SYNC   = 2;
  // Group 1: upper nibble of the 8-bit port plus the three pins of the second port
  localparam logic [PCI_PINS-1:0] PCI_GRP1_SEL = 11'b111_1111_0000;

  function automatic logic [PCI_PINS-1:0] grp_members(input int g,
                                                     input logic [PCI_PINS-1:0] g1_sel);
    return (g == 0) ? ~g1_sel : g1_sel;
  endfunction
endpackage

// File: rtl/pci_sync.sv
module pci_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pci_change_det.sv
module pci_change_det #(
  parameter int WIDTH = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] suppress,
  output logic [WIDTH-1:0] changed
);
  logic [WIDTH-1:0] prev_q;

  // The previous sample tracks every cycle, masked or not, so the
  // reference level is already current when a mask is lifted.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign changed[i] = (lvl[i] ^ prev_q[i]) & ~suppress[i];
    end
  endgenerate
endmodule

// File: rtl/pci_flag.sv
module pci_flag #(
  parameter int                  WIDTH  = 11,
  parameter int                  GROUPS = 2,
  parameter logic [WIDTH-1:0]    G1_SEL = 11'b111_1111_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  changed,
  input  logic [GROUPS-1:0] grp_en,
  input  logic              ack,
  output logic              set_any,
  output logic              flag_q,
  output logic              irq_q
);
  import pin_change_irq_pkg::*;

  logic [GROUPS-1:0] grp_hit;
  logic              flag_d;

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      localparam logic [WIDTH-1:0] MEMB = grp_members(g, G1_SEL);
      assign grp_hit[g] = grp_en[g] & |(changed & MEMB);
    end
  endgenerate

  assign set_any = |grp_hit;

  always_comb begin
    flag_d = flag_q;
    if (ack)     flag_d = 1'b0;
    if (set_any) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & |grp_en;
    end
  end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pin_change_irq_pkg::*;
#(
  parameter int                    NUM_PINS    = PCI_PINS,
  parameter int                    SYNC_STAGES = PCI_SYNC,
  parameter logic [NUM_PINS-1:0]   GRP1_SEL    = PCI_GRP1_SEL
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic [1:0]            grp_en,
  input  logic [NUM_PINS-1:0]   alt_active,
  input  logic                  ack,
  output logic                  chg_flag,
  output logic                  irq_req
);
  localparam int GROUPS = PCI_GROUPS;

  logic [NUM_PINS-1:0] lvl_sync;
  logic [NUM_PINS-1:0] changed;
  logic                set_any;

  pci_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pin_in), .q_sync(lvl_sync)
  );

  pci_change_det #(.WIDTH(NUM_PINS)) u_det (
    .clk(clk), .rst(rst), .lvl(lvl_sync), .suppress(alt_active), .changed(changed)
  );

  pci_flag #(.WIDTH(NUM_PINS), .GROUPS(GROUPS), .G1_SEL(GRP1_SEL)) u_flag (
    .clk(clk), .rst(rst), .changed(changed), .grp_en(grp_en), .ack(ack),
    .set_any(set_any), .flag_q(chg_flag), .irq_q(irq_req)
  );
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int NUM_PINS = 11
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          grp_en,
  input logic [NUM_PINS-1:0] alt_active,
  input logic                ack,
  input logic                set_any,
  input logic                chg_flag,
  input logic                irq_req
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (!chg_flag && !irq_req));
  // R4
  disabled_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_en == 2'b00) |=> !$rose(chg_flag));
  // R5
  all_masked_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((&alt_active) && !chg_flag) |=> !chg_flag);
  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !set_any) |=> !chg_flag);
  // R8
  set_beats_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && set_any) |=> chg_flag);
  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> chg_flag);
  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_en == 2'b00) |=> !irq_req);
  // R10
  flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_flag && !ack) |=> chg_flag);
endmodule

bind pin_change_irq pin_change_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .grp_en(grp_en), .alt_active(alt_active), .ack(ack),
  .set_any(set_any), .chg_flag(chg_flag), .irq_req(irq_req)
);

// File: tb/tb_pin_change_irq.sv
`timescale 1ns/1ps
module tb_pin_change_irq;
  localparam int NP = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_in = '0;
  logic [1:0]    grp_en = 2'b00;
  logic [NP-1:0] alt_active = '0;
  logic          ack = 1'b0;
  logic          chg_flag, irq_req;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct {
    int    at;
    logic  flag;
    logic  irq;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  pin_change_irq dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .grp_en(grp_en),
    .alt_active(alt_active), .ack(ack), .chg_flag(chg_flag), .irq_req(irq_req)
  );

  // monitor: pops and compares expectations just after each edge
  always @(posedge clk) begin
    cyc++;
    #1;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      tests++;
      if (chg_flag !== e.flag || irq_req !== e.irq) begin
        fails++;
        $display("FAIL %s: flag/irq = %b/%b expected %b/%b (cycle %0d)",
                 e.tag, chg_flag, irq_req, e.flag, e.irq, cyc);
      end
    end
  end

  task automatic expect_in(input int d, input logic f, input logic i, input string tag);
    exp_t e;
    e.at = cyc + d; e.flag = f; e.irq = i; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    tick(2);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    expect_in(1, 1'b0, 1'b0, "R1 after reset");
    tick(3);

    // R2 rising edge on group-0 pin 0
    grp_en = 2'b01;
    @(negedge clk); pin_in[0] = 1'b1;
    expect_in(2, 1'b0, 1'b0, "R2 not yet after two edges");
    expect_in(3, 1'b1, 1'b1, "R2 rising sets flag");
    tick(6);
    expect_in(1, 1'b1, 1'b1, "R10 flag held");
    tick(1);
    // R7
    @(negedge clk); ack = 1'b1;
    expect_in(1, 1'b0, 1'b0, "R7 ack clears");
    @(negedge clk); ack = 1'b0;
    tick(2);

    // R2 falling edge
    @(negedge clk); pin_in[0] = 1'b0;
    expect_in(3, 1'b1, 1'b1, "R2 falling sets flag");
    tick(5); clear_flag();

    // R3 second-port pin and upper nibble
    grp_en = 2'b10;
    @(negedge clk); pin_in[9] = 1'b1;
    expect_in(3, 1'b1, 1'b1, "R3 second-port pin sets flag");
    tick(5); clear_flag();
    @(negedge clk); pin_in[4] = 1'b1;
    expect_in(3, 1'b1, 1'b1, "R3 upper-nibble pin sets flag");
    tick(5); clear_flag();

    // R4 group 1 disabled
    grp_en = 2'b01;
    @(negedge clk); pin_in[5] = 1'b1;
    expect_in(3, 1'b0, 1'b0, "R4 disabled group no flag");
    tick(6);
    grp_en = 2'b11;
    expect_in(3, 1'b0, 1'b0, "R4 late enable no flag");
    tick(5);
    grp_en = 2'b00;
    @(negedge clk); pin_in[1] = 1'b1;
    expect_in(3, 1'b0, 1'b0, "R4 both disabled no flag");
    tick(6);

    // R5 / R6 alternate-function mask
    grp_en = 2'b11;
    alt_active[2] = 1'b1;
    tick(1);
    @(negedge clk); pin_in[2] = 1'b1;
    expect_in(3, 1'b0, 1'b0, "R5 masked pin no flag");
    tick(6);
    alt_active[2] = 1'b0;
    expect_in(3, 1'b0, 1'b0, "R6 unmask no false change");
    tick(6);

    // R8 change coinciding with ack
    @(negedge clk); pin_in[1] = 1'b0;
    expect_in(3, 1'b1, 1'b1, "R8 setup flag");
    tick(6);
    @(negedge clk); pin_in[10] = 1'b1;
    tick(2);
    ack = 1'b1;
    expect_in(1, 1'b1, 1'b1, "R8 change wins over ack");
    @(negedge clk); ack = 1'b0;
    tick(3); clear_flag();

    // R9 request gated by enables while flag holds
    grp_en = 2'b01;
    @(negedge clk); pin_in[3] = 1'b1; pin_in[6] = 1'b1;
    expect_in(3, 1'b1, 1'b1, "R9 flag and request set");
    tick(6);
    grp_en = 2'b00;
    expect_in(1, 1'b1, 1'b0, "R9 request drops, flag holds");
    tick(3);
    @(negedge clk); ack = 1'b1;
    expect_in(1, 1'b0, 1'b0, "R7 ack with groups disabled");
    @(negedge clk); ack = 1'b0;
    tick(4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: finished=0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule